// File: doc/BRIEF.md
# Per-Core Bandwidth Share Limiter

This block sits between a set of core request ports and the shared arbiter that feeds the memory controller. It counts every request each core gets served. It compares that core's share of all served requests against a per-core percentage ceiling. When the share reaches the ceiling, the block stops admitting new requests from that core. It admits that core again once the share drops back below the ceiling.

Only cores marked as memory-intensive are subject to the ceiling. Light cores always pass through, which gives them relative priority over the heavy ones. A small register port holds the per-core ceilings and the intensity mask.

Usage is measured over fixed windows of `WIN` cycles. The limit decision looks at two counts added together: the counts of the last completed window and the running counts of the current window. Traffic therefore ages out after two windows. The share test uses integer cross-multiplication, so no divider is needed.

Top module: `core_bw_gate`

## Requirements
- R1: After reset every ceiling reads 0 and the intensity mask reads 0. No core is blocked, so `core_ready` equals `arb_ready` and `arb_valid` equals `core_valid`.
- R2: A core that is not blocked passes straight through: `arb_valid[i] = core_valid[i]` and `core_ready[i] = arb_ready[i]`. A served request is a cycle in which `core_valid[i]` and `core_ready[i]` are both 1.
- R3: Define the core's usage U as its served requests in the last completed window plus the current window, and the total T as the same sum over all cores. Core i is blocked when all of these hold: its intensity bit is 1, its ceiling P is nonzero, T is nonzero, and 100*U >= P*T. A blocked core sees `core_ready[i]=0`, and `arb_valid[i]=0`.
- R4: A blocked core is admitted again in the first cycle in which 100*U < P*T.
- R5: A core whose intensity bit is 0 is never blocked, whatever its ceiling or share.
- R6: A ceiling of 0 disables limiting for that core.
- R7: A window ends every `WIN` cycles after reset. At the end of a window, the just-finished counts replace the previous-window counts and the running counts restart at zero. With no further service, every core is unblocked within two windows.
- R8: Register map. A write to address i (i < N) sets core i's ceiling. The written value is clamped, so that any value above 100 is stored as 100. Address N holds the intensity mask, where bit i = 1 marks core i as intensive. Reads are combinational. Any other address reads 0, and writes to it are ignored.
- R9: Requests already handed over are never withdrawn. `arb_valid[i]` is never 1 unless `core_valid[i]` is 1, and limiting only withholds new handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | N | Request valid from each core |
| core_ready | output | N | Acceptance back to each core |
| arb_valid | output | N | Request valid forwarded to the arbiter |
| arb_ready | input | N | Per-core grant from the arbiter |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address, AW = clog2(N+1) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |

## Verification
Several properties are checked on every cycle:
- light cores and cores with a zero ceiling always pass straight through;
- a forwarded request always has a core request behind it;
- a core sees a completed handshake exactly when the arbiter does;
- the running total restarts after each window end;
- nothing is blocked while no traffic has been counted.

The share arithmetic itself can only be shown by the bench's scenarios. Those scenarios cover the exact cycle a heavy core crosses its ceiling, its release as other cores dilute its share, aging over two windows, and ceiling clamping. The bench predicts each of these from its own window model.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
   localparam int PCT_W   = 7;
   localparam int PCT_MAX = 100;
   localparam int DW      = 8;

   function automatic logic [PCT_W-1:0] pct_clamp(input logic [DW-1:0] v);
      return (v > DW'(PCT_MAX)) ? PCT_W'(PCT_MAX) : v[PCT_W-1:0];
   endfunction
endpackage

// File: rtl/bwg_cfg_regs.sv
module bwg_cfg_regs
   import bwg_pkg::*;
#(
   parameter int N  = 8,
   parameter int AW = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [AW-1:0]             addr,
   input  logic [DW-1:0]             wdata,
   output logic [N-1:0][PCT_W-1:0]   thr_q,
   output logic [N-1:0]              tag_q,
   output logic [DW-1:0]             rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q <= '0;
         tag_q <= '0;
      end else if (we) begin
         for (int i = 0; i < N; i++)
            if (addr == AW'(i)) thr_q[i] <= pct_clamp(wdata);
         if (addr == AW'(N)) tag_q <= wdata[N-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N; i++)
         if (addr == AW'(i)) rdata = DW'(thr_q[i]);
      if (addr == AW'(N)) rdata = DW'(tag_q);
   end
endmodule

// File: rtl/bwg_win_tot.sv
module bwg_win_tot #(
   parameter int N   = 8,
   parameter int WIN = 64,
   localparam int WC_W  = $clog2(WIN),
   localparam int PC_W  = $clog2(N + 1),
   localparam int TC_W  = $clog2(N * WIN + 1),
   localparam int TOT_W = $clog2(2 * N * WIN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     served,
   output logic             wend,
   output logic [TC_W-1:0]  tot_cur,
   output logic [TOT_W-1:0] tot_sum
);
   logic [WC_W-1:0] wcnt;
   logic [PC_W-1:0] pc;
   logic [TC_W-1:0] tot_last;

   always_comb begin
      pc = '0;
      for (int i = 0; i < N; i++) pc = pc + PC_W'(served[i]);
   end

   assign wend    = (wcnt == WC_W'(WIN - 1));
   assign tot_sum = TOT_W'(tot_cur) + TOT_W'(tot_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt     <= '0;
         tot_cur  <= '0;
         tot_last <= '0;
      end else if (wend) begin
         wcnt     <= '0;
         tot_last <= tot_cur + TC_W'(pc);
         tot_cur  <= '0;
      end else begin
         wcnt    <= wcnt + 1'b1;
         tot_cur <= tot_cur + TC_W'(pc);
      end
   end
endmodule

// File: rtl/bwg_core_meter.sv
module bwg_core_meter
   import bwg_pkg::*;
#(
   parameter int WIN   = 64,
   parameter int TOT_W = 11,
   localparam int C_W   = $clog2(WIN + 1),
   localparam int U_W   = C_W + 1,
   localparam int CMP_W = TOT_W + PCT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             served,
   input  logic             wend,
   input  logic [PCT_W-1:0] thr,
   input  logic             intensive,
   input  logic [TOT_W-1:0] tot_sum,
   output logic             blocked
);
   logic [C_W-1:0]   cur, last;
   logic [U_W-1:0]   use_sum;
   logic [CMP_W-1:0] lhs, rhs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur  <= '0;
         last <= '0;
      end else if (wend) begin
         last <= cur + C_W'(served);
         cur  <= '0;
      end else begin
         cur <= cur + C_W'(served);
      end
   end

   assign use_sum = U_W'(cur) + U_W'(last);
   assign lhs     = CMP_W'(use_sum) * CMP_W'(PCT_MAX);
   assign rhs     = CMP_W'(thr) * CMP_W'(tot_sum);
   assign blocked = intensive && (thr != '0) && (tot_sum != '0) && (lhs >= rhs);
endmodule

// File: rtl/core_bw_gate.sv
module core_bw_gate
   import bwg_pkg::*;
#(
   parameter int N   = 8,
   parameter int WIN = 64,
   localparam int AW = $clog2(N + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    core_valid,
   output logic [N-1:0]    core_ready,
   output logic [N-1:0]    arb_valid,
   input  logic [N-1:0]    arb_ready,
   input  logic            cfg_we,
   input  logic [AW-1:0]   cfg_addr,
   input  logic [DW-1:0]   cfg_wdata,
   output logic [DW-1:0]   cfg_rdata
);
   localparam int TC_W  = $clog2(N * WIN + 1);
   localparam int TOT_W = $clog2(2 * N * WIN + 1);

   generate
      if (N < 1 || N > DW) begin : g_bad_n
         $error("core_bw_gate: N must be between 1 and DW");
      end
      if (WIN < 2) begin : g_bad_win
         $error("core_bw_gate: WIN must be at least 2");
      end
   endgenerate

   logic [N-1:0][PCT_W-1:0] thr_q;
   logic [N-1:0]            tag_q;
   logic [N-1:0]            blocked, served;
   logic                    wend;
   logic [TC_W-1:0]         tot_cur;
   logic [TOT_W-1:0]        tot_sum;

   assign core_ready = arb_ready & ~blocked;
   assign arb_valid  = core_valid & ~blocked;
   assign served     = core_valid & core_ready;

   bwg_cfg_regs #(.N(N), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .thr_q(thr_q), .tag_q(tag_q), .rdata(cfg_rdata)
   );

   bwg_win_tot #(.N(N), .WIN(WIN)) u_win (
      .clk(clk), .rst_n(rst_n), .served(served),
      .wend(wend), .tot_cur(tot_cur), .tot_sum(tot_sum)
   );

   generate
      for (genvar i = 0; i < N; i++) begin : g_core
         bwg_core_meter #(.WIN(WIN), .TOT_W(TOT_W)) u_meter (
            .clk(clk), .rst_n(rst_n), .served(served[i]), .wend(wend),
            .thr(thr_q[i]), .intensive(tag_q[i]), .tot_sum(tot_sum),
            .blocked(blocked[i])
         );
      end
   endgenerate
endmodule

// File: rtl/core_bw_gate_chk.sv
module core_bw_gate_chk
   import bwg_pkg::*;
#(
   parameter int N    = 8,
   parameter int TC_W = 10,
   parameter int TOT_W = 11
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [N-1:0]            core_valid,
   input logic [N-1:0]            core_ready,
   input logic [N-1:0]            arb_valid,
   input logic [N-1:0]            arb_ready,
   input logic [N-1:0][PCT_W-1:0] thr_q,
   input logic [N-1:0]            tag_q,
   input logic                    wend,
   input logic [TC_W-1:0]         tot_cur,
   input logic [TOT_W-1:0]        tot_sum
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_p
         // R5
         light_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !tag_q[i] |-> (core_ready[i] == arb_ready[i]) && (arb_valid[i] == core_valid[i]))
            else $error("light core %0d was limited", i);
         // R6
         zero_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_q[i] == '0) |-> (core_ready[i] == arb_ready[i]) && (arb_valid[i] == core_valid[i]))
            else $error("core %0d limited with zero ceiling", i);
         // R9
         no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
            arb_valid[i] |-> core_valid[i])
            else $error("core %0d forwarded without request", i);
         // R2
         hs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (arb_valid[i] && arb_ready[i]) |-> (core_valid[i] && core_ready[i]))
            else $error("core %0d handshake mismatch", i);
      end
   endgenerate

   // R7
   win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wend |=> (tot_cur == '0))
      else $error("running total not cleared at window end");

   // R3
   idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tot_sum == '0) |-> (core_ready == arb_ready))
      else $error("core blocked with empty history");
endmodule

bind core_bw_gate core_bw_gate_chk #(.N(N), .TC_W(TC_W), .TOT_W(TOT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_ready(core_ready),
   .arb_valid(arb_valid), .arb_ready(arb_ready), .thr_q(thr_q), .tag_q(tag_q),
   .wend(wend), .tot_cur(tot_cur), .tot_sum(tot_sum)
);

// File: tb/sim_core_bw_gate.sv
module sim_core_bw_gate;
   localparam int N = 8;
   localparam int WIN = 16;

   typedef struct {
      logic [N-1:0] rdy;
      logic [N-1:0] av;
      string        tag;
   } item_t;

   logic clk = 0, rst_n = 0;
   logic [N-1:0] core_valid = '0, arb_ready = '0;
   logic [N-1:0] core_ready, arb_valid;
   logic cfg_we = 0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0, cfg_rdata;

   int n_chk = 0, n_fail = 0;
   item_t q[$];
   event smp;

   // bench model state
   int m_cur[N], m_last[N], m_ct = 0, m_lt = 0, m_wc = 0;
   int m_thr[N];
   logic [N-1:0] m_tag = '0;
   bit rd_en = 0; logic [7:0] rd_exp = '0; string rd_tag = "R8";
   bit seen_blk0, seen_pass0;
   logic last_av0;

   core_bw_gate #(.N(N), .WIN(WIN)) u0 (
      .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_ready(core_ready),
      .arb_valid(arb_valid), .arb_ready(arb_ready), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit mblk(input int i);
      int ts, us;
      ts = m_ct + m_lt;
      us = m_cur[i] + m_last[i];
      return m_tag[i] && (m_thr[i] != 0) && (ts != 0) && (us * 100 >= m_thr[i] * ts);
   endfunction

   // one clock cycle: drive, predict, sample, update model
   task automatic cyc(input logic [N-1:0] v, input logic [N-1:0] ar,
                      input string tag = "R2", input logic we = 0,
                      input logic [3:0] a = 0, input logic [7:0] d = 0);
      item_t it;
      logic [N-1:0] blk;
      int pc;
      core_valid = v; arb_ready = ar; cfg_we = we; cfg_addr = a; cfg_wdata = d;
      for (int i = 0; i < N; i++) blk[i] = mblk(i);
      it.rdy = ar & ~blk; it.av = v & ~blk; it.tag = tag;
      q.push_back(it);
      #2;
      ->smp;
      if (rd_en) chk(rd_tag, cfg_rdata, rd_exp);
      if (v[0] && !arb_valid[0]) seen_blk0 = 1;
      if (v[0] && arb_valid[0]) seen_pass0 = 1;
      last_av0 = arb_valid[0];
      @(posedge clk);
      pc = 0;
      for (int i = 0; i < N; i++) pc += int'(v[i] & it.rdy[i]);
      if (m_wc == WIN - 1) begin
         for (int i = 0; i < N; i++) begin
            m_last[i] = m_cur[i] + int'(v[i] & it.rdy[i]);
            m_cur[i] = 0;
         end
         m_lt = m_ct + pc; m_ct = 0; m_wc = 0;
      end else begin
         for (int i = 0; i < N; i++) m_cur[i] += int'(v[i] & it.rdy[i]);
         m_ct += pc; m_wc++;
      end
      if (we) begin
         if (a < N) m_thr[a] = (d > 100) ? 100 : int'(d);
         else if (a == N) m_tag = d;
      end
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      cyc('0, '0, "R8", 1'b1, a, d);
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      rd_en = 1; rd_exp = e; rd_tag = tag;
      cyc('0, '0, tag, 1'b0, a, 8'h0);
      rd_en = 0;
   endtask

   // scoreboard monitor
   initial begin
      item_t it;
      forever begin
         @(smp);
         it = q.pop_front();
         chk({it.tag, " ready"}, core_ready, it.rdy);
         chk({it.tag, " arb_valid"}, arb_valid, it.av);
      end
   end

   // watchdog
   initial begin
      #(20 * 200000);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_cur[i] = 0; m_last[i] = 0; m_thr[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      cyc('1, '1, "R1");
      rd(4'd0, 8'd0, "R1");
      rd(4'd8, 8'd0, "R1");
      // R8 register map and clamping
      wr(4'd0, 8'd20);
      rd(4'd0, 8'd20, "R8");
      wr(4'd1, 8'd150);
      rd(4'd1, 8'd100, "R8");
      wr(4'd12, 8'd55);
      rd(4'd12, 8'd0, "R8");
      rd(4'd0, 8'd20, "R8");
      wr(4'd8, 8'h01);
      rd(4'd8, 8'h01, "R8");
      // R3: core0 takes half of the traffic with a 20 percent ceiling
      seen_blk0 = 0;
      for (int k = 0; k < 40; k++) cyc(8'h03, '1, "R3");
      chk("R3 core0 blocked", 32'(seen_blk0), 32'd1);
      // R4: other cores dilute core0's share
      seen_pass0 = 0;
      for (int k = 0; k < 40; k++) cyc('1, '1, "R4");
      chk("R4 core0 released", 32'(seen_pass0), 32'd1);
      // R6: zero ceiling on an intensive core
      wr(4'd0, 8'd0);
      seen_blk0 = 0;
      for (int k = 0; k < 20; k++) cyc(8'h01, '1, "R6");
      chk("R6 never blocked", 32'(seen_blk0), 32'd0);
      // R7: aging over two windows
      wr(4'd0, 8'd20);
      seen_blk0 = 0;
      for (int k = 0; k < 10; k++) cyc(8'h01, '1, "R7");
      chk("R7 blocked alone", 32'(seen_blk0), 32'd1);
      for (int k = 0; k < 2 * WIN + 2; k++) cyc(8'h01, '0, "R7");
      chk("R7 aged out", 32'(last_av0), 32'd1);
      // R9: no request, nothing forwarded
      for (int k = 0; k < 4; k++) cyc('0, '1, "R9");
      chk("R9 arb_valid idle", 32'(arb_valid), 32'd0);
      // R5: core0 marked light with a nonzero ceiling
      wr(4'd8, 8'h00);
      seen_blk0 = 0;
      for (int k = 0; k < 20; k++) cyc(8'h01, '1, "R5");
      chk("R5 light core open", 32'(seen_blk0), 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule